// File: doc/BRIEF.md
# Comma Detector and Word Aligner

This block sits right after a deserializer that delivers 10 raw line bits per word. The word boundaries are arbitrary. The block looks for comma patterns at every bit position of the incoming stream. When it finds an enabled comma at a bit offset other than the current one, it moves the word boundary so that the comma starts a 10-bit output character. It then pulses a realign indicator. Each output character whose first seven bits form an enabled comma also carries a comma-detected flag.

Both comma patterns come in on ports, so software or a neighbouring block can set them. The conventional values are a plus comma of 0011111 and a minus comma of 1100000, written in the order the bits are received. Two separate enables decide whether each pattern may move the boundary. With both enables low, the boundary stays where it is.

Data moves on a valid/ready stream on both sides, with a single output register. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output word and its flag are held and no input is taken.

Top module: `comma_aligner`

## Requirements
- R1: During and after a synchronous reset, `out_valid`, `realign` and `comma_det` are low and the boundary offset is 0. Until the first realignment, output words equal the accepted input words in order.
- R2: A comma is a 10-bit window whose first seven received bits equal `plus_pat` or `minus_pat`. Pattern bit 0 is the first bit received. The last three bits of the window are not examined.
- R3: A plus comma can move the boundary only while `plus_en` is high, and a minus comma only while `minus_en` is high. Each enable is independent of the other.
- R4: When an enabled comma starts at a bit offset different from the current one, the boundary moves to that offset. `realign` is high for exactly one cycle. The next output word transferred after the pulse starts with that comma; under continuous flow this is the cycle after the pulse.
- R5: A comma found on the current boundary produces no realign pulse and leaves the offset unchanged.
- R6: Every comma occurrence is checked, not only the first. A later comma at yet another offset causes a further realignment.
- R7: With both enables low, the boundary never moves and `realign` stays low, whatever patterns arrive.
- R8: If enabled commas match at several offsets within one search, the lowest offset is chosen.
- R9: `comma_det` is high together with an output word whose first seven bits match a pattern whose enable is high. Otherwise it is low.
- R10: `in_ready` equals `!out_valid || out_ready`. A held output word stays stable until it is taken. No accepted word is lost or repeated: N accepted words give N-2 output words.
- R11: `in_data[0]` is the earliest received bit. Output word m, counted from 0, is the ten stream bits that start at bit 10·m + offset of the accepted stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| plus_en | input | 1 | Allows realignment on the plus comma |
| minus_en | input | 1 | Allows realignment on the minus comma |
| plus_pat | input | 7 | Plus comma pattern, bit 0 received first |
| minus_pat | input | 7 | Minus comma pattern, bit 0 received first |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | 10 | Raw line bits, bit 0 received first |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 10 | Aligned character |
| comma_det | output | 1 | Output word begins with an enabled comma |
| realign | output | 1 | One-cycle pulse when the boundary moved |

## Verification
The hardest case to reach from the ports is two enabled commas matching inside the same search window, because only one of them may win. The stimulus builds a bit stream in which a plus comma at offset 1 is followed at once by a minus comma at offset 8 of the same word. Filler bits alternate so that no accidental comma appears anywhere else. Back-pressure is exercised by dropping `out_ready` in a fixed rhythm and inserting gaps in `in_valid`, and the bench compares the whole output sequence against the shifted input stream.

// File: rtl/ca_pkg.sv
package ca_pkg;
  localparam int unsigned CA_WORD_W  = 10;
  localparam int unsigned CA_COMMA_W = 7;

  typedef struct packed {
    logic plus;
    logic minus;
  } ca_sel_t;
endpackage

// File: rtl/ca_history.sv
module ca_history #(
  parameter int unsigned WORD_W  = ca_pkg::CA_WORD_W,
  parameter int unsigned COMMA_W = ca_pkg::CA_COMMA_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          acc,
  input  logic [WORD_W-1:0]             in_data,
  output logic [2*WORD_W-1:0]           pair,
  output logic [WORD_W+COMMA_W-2:0]     window,
  output logic                          search_ok,
  output logic                          out_ok
);
  logic [WORD_W-1:0] w_old, w_new;
  logic [1:0]        fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_old <= '0;
      w_new <= '0;
      fill  <= 2'd0;
    end else if (acc) begin
      w_old <= w_new;
      w_new <= in_data;
      if (fill != 2'd2) fill <= fill + 2'd1;
    end
  end

  // older word in the low half: low bit index = earlier in time
  assign pair      = {w_new, w_old};
  assign window    = {in_data[COMMA_W-2:0], w_new};
  assign search_ok = (fill != 2'd0);
  assign out_ok    = (fill == 2'd2);

  // R10
  fill_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (fill == 2'd2) |=> (fill == 2'd2))
    else $error("history fill count left its saturated value");
endmodule

// File: rtl/ca_search.sv
module ca_search
  import ca_pkg::*;
#(
  parameter int unsigned WORD_W  = CA_WORD_W,
  parameter int unsigned COMMA_W = CA_COMMA_W,
  parameter int unsigned OFF_W   = $clog2(WORD_W)
) (
  input  logic [WORD_W+COMMA_W-2:0] window,
  input  logic [COMMA_W-1:0]        plus_pat,
  input  logic [COMMA_W-1:0]        minus_pat,
  input  ca_sel_t                   en,
  output logic                      hit,
  output logic [OFF_W-1:0]          hit_off
);
  logic [WORD_W-1:0] mvec;

  for (genvar k = 0; k < WORD_W; k++) begin : g_off
    assign mvec[k] = (en.plus  && (window[k +: COMMA_W] == plus_pat)) ||
                     (en.minus && (window[k +: COMMA_W] == minus_pat));
  end

  // lowest matching offset wins
  always_comb begin
    hit_off = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (mvec[i]) hit_off = OFF_W'(i);
    end
  end

  assign hit = |mvec;
endmodule

// File: rtl/ca_boundary.sv
module ca_boundary #(
  parameter int unsigned WORD_W = ca_pkg::CA_WORD_W,
  parameter int unsigned OFF_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             search_ok,
  input  logic             hit,
  input  logic [OFF_W-1:0] hit_off,
  output logic [OFF_W-1:0] off,
  output logic             realign
);
  logic move;

  assign move = acc && search_ok && hit && (hit_off != off);

  always_ff @(posedge clk) begin
    if (rst) begin
      off     <= '0;
      realign <= 1'b0;
    end else begin
      realign <= move;
      if (move) off <= hit_off;
    end
  end

  // R4
  off_move_chk: assert property (@(posedge clk) disable iff (rst)
    (off != $past(off)) |-> realign)
    else $error("boundary moved without a realign pulse");

  // R4
  off_range_chk: assert property (@(posedge clk) disable iff (rst)
    off < OFF_W'(WORD_W))
    else $error("boundary offset out of range");

  // R5
  same_off_chk: assert property (@(posedge clk) disable iff (rst)
    realign |-> (off != $past(off)))
    else $error("realign pulse without a boundary change");
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
  import ca_pkg::*;
#(
  parameter int unsigned WORD_W  = CA_WORD_W,
  parameter int unsigned COMMA_W = CA_COMMA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               plus_en,
  input  logic               minus_en,
  input  logic [COMMA_W-1:0] plus_pat,
  input  logic [COMMA_W-1:0] minus_pat,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_data,
  output logic               comma_det,
  output logic               realign
);
  localparam int unsigned OFF_W = $clog2(WORD_W);
  localparam int unsigned WIN_W = WORD_W + COMMA_W - 1;

  ca_sel_t                en;
  logic                   advance, acc;
  logic [2*WORD_W-1:0]    pair;
  logic [WIN_W-1:0]       window;
  logic                   search_ok, out_ok, hit;
  logic [OFF_W-1:0]       hit_off, off;
  logic [WORD_W-1:0]      word;
  logic                   det;

  assign en      = '{plus: plus_en, minus: minus_en};
  assign advance = !out_valid || out_ready;
  assign in_ready = advance;
  assign acc     = in_valid && advance;

  ca_history #(.WORD_W(WORD_W), .COMMA_W(COMMA_W)) u_hist (
    .clk(clk), .rst(rst), .acc(acc), .in_data(in_data),
    .pair(pair), .window(window), .search_ok(search_ok), .out_ok(out_ok)
  );

  ca_search #(.WORD_W(WORD_W), .COMMA_W(COMMA_W), .OFF_W(OFF_W)) u_search (
    .window(window), .plus_pat(plus_pat), .minus_pat(minus_pat), .en(en),
    .hit(hit), .hit_off(hit_off)
  );

  ca_boundary #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_bound (
    .clk(clk), .rst(rst), .acc(acc), .search_ok(search_ok),
    .hit(hit), .hit_off(hit_off), .off(off), .realign(realign)
  );

  assign word = pair[off +: WORD_W];
  assign det  = (en.plus  && (word[COMMA_W-1:0] == plus_pat)) ||
                (en.minus && (word[COMMA_W-1:0] == minus_pat));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      comma_det <= 1'b0;
    end else if (acc) begin
      out_valid <= out_ok;
      out_data  <= word;
      comma_det <= out_ok && det;
    end else if (advance) begin
      out_valid <= 1'b0;
      comma_det <= 1'b0;
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
    else $error("held output word changed");

  // R9
  det_valid_chk: assert property (@(posedge clk) disable iff (rst)
    comma_det |-> out_valid)
    else $error("comma flag without a valid word");

  // R7 (also R3): no realignment without an enable
  realign_en_chk: assert property (@(posedge clk) disable iff (rst)
    realign |-> $past(plus_en || minus_en))
    else $error("realign while both enables were low");
endmodule

// File: tb/tb_comma_aligner.sv
`timescale 1ns/1ps
module tb_comma_aligner;
  localparam logic [9:0] K_PLUS  = 10'b0101111100;
  localparam logic [9:0] K_MINUS = 10'b1010000011;
  localparam logic [6:0] P_PAT   = 7'b1111100;
  localparam logic [6:0] M_PAT   = 7'b0000011;

  logic clk = 1'b0, rst = 1'b1;
  logic plus_en = 1'b0, minus_en = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [9:0] in_data = '0;
  wire in_ready, out_valid, comma_det, realign;
  wire [9:0] out_data;

  comma_aligner dut (
    .clk(clk), .rst(rst), .plus_en(plus_en), .minus_en(minus_en),
    .plus_pat(P_PAT), .minus_pat(M_PAT), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .comma_det(comma_det),
    .realign(realign)
  );

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  bit stream [256];
  int slen;
  logic [9:0] got_d [64];
  bit got_c [64];
  int ocnt, rl_n;
  int rl_idx [16];
  int exp_sw_n;
  int exp_idx [4];
  int exp_off [4];
  bit mon_on = 1'b0, bp_en = 1'b0, gap_en = 1'b0;
  bit prev_stall = 1'b0;
  logic [9:0] prev_data;
  int rcyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      rcyc++;
      out_ready = bp_en ? (rcyc % 5 >= 2) : 1'b1;
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      if (bp_en) begin
        chk(in_ready == (!out_valid || out_ready), "R10", "in_ready",
            int'(in_ready), int'(!out_valid || out_ready));
        if (prev_stall)
          chk(out_valid && out_data == prev_data, "R10", "held word",
              int'(out_data), int'(prev_data));
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (realign && rl_n < 16) begin
        rl_idx[rl_n] = ocnt + ((out_valid && out_ready) ? 1 : 0);
        rl_n++;
      end
      if (out_valid && out_ready && ocnt < 64) begin
        got_d[ocnt] = out_data;
        got_c[ocnt] = comma_det;
        ocnt++;
      end
    end
  end

  task automatic push_n(input logic [9:0] v, input int n);
    for (int j = 0; j < n; j++) begin
      stream[slen] = v[j];
      slen++;
    end
  endtask

  task automatic fill_to(input int n);
    while (slen < n) begin
      stream[slen] = (slen == 0) ? 1'b0 : ~stream[slen-1];
      slen++;
    end
  endtask

  task automatic apply_reset();
    @(posedge clk); #1;
    rst = 1'b1; in_valid = 1'b0; bp_en = 1'b0; gap_en = 1'b0; mon_on = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(!realign && !comma_det, "R1", "flags in reset",
        int'({realign, comma_det}), 0);
    chk(in_ready, "R1", "in_ready in reset", int'(in_ready), 1);
    ocnt = 0; rl_n = 0; slen = 0; exp_sw_n = 0; prev_stall = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0; mon_on = 1'b1;
  endtask

  task automatic drive(input int nw);
    bit ok;
    for (int i = 0; i < nw; i++) begin
      if (gap_en && (i % 3 == 2)) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      in_valid = 1'b1;
      for (int j = 0; j < 10; j++) in_data[j] = stream[10*i + j];
      do begin
        @(negedge clk); ok = in_ready;
        @(posedge clk); #1;
      end while (!ok);
    end
    in_valid = 1'b0;
    repeat (14) @(posedge clk);
    #1;
  endtask

  task automatic check_all(input int nw, input string req);
    int off;
    logic [9:0] ew;
    logic [6:0] h;
    bit ed;
    chk(ocnt == nw - 2, "R10", "output word count", ocnt, nw - 2);
    for (int m = 0; m < ocnt && m < nw - 2; m++) begin
      off = 0;
      for (int s = 0; s < exp_sw_n; s++) if (m >= exp_idx[s]) off = exp_off[s];
      for (int j = 0; j < 10; j++) ew[j] = stream[10*m + off + j];
      h  = ew[6:0];
      ed = (plus_en && h == P_PAT) || (minus_en && h == M_PAT);
      chk(got_d[m] == ew, req, $sformatf("word %0d", m), int'(got_d[m]), int'(ew));
      chk(got_c[m] == ed, "R9", $sformatf("comma flag word %0d", m),
          int'(got_c[m]), int'(ed));
    end
    chk(rl_n == exp_sw_n, req, "realign count", rl_n, exp_sw_n);
    for (int s = 0; s < rl_n && s < exp_sw_n; s++)
      chk(rl_idx[s] == exp_idx[s], req, "realign position", rl_idx[s], exp_idx[s]);
  endtask

  // R1, R11: no commas, boundary stays at 0
  task automatic t_passthru();
    apply_reset();
    plus_en = 1'b1; minus_en = 1'b1;
    fill_to(80);
    drive(8);
    check_all(8, "R11");
  endtask

  // R4, R5, R3: plus only; minus ignored; repeat at same offset
  task automatic t_plus();
    apply_reset();
    plus_en = 1'b1; minus_en = 1'b0;
    fill_to(43); push_n(K_PLUS, 10);
    fill_to(66); push_n(K_MINUS, 10);
    fill_to(83); push_n(K_PLUS, 10);
    fill_to(130);
    exp_sw_n = 1; exp_idx[0] = 4; exp_off[0] = 3;
    drive(13);
    check_all(13, "R4");
  endtask

  // R6, R3: minus only, two realignments, plus ignored
  task automatic t_minus();
    apply_reset();
    plus_en = 1'b0; minus_en = 1'b1;
    fill_to(37); push_n(K_MINUS, 10);
    fill_to(62); push_n(K_PLUS, 10);
    fill_to(95); push_n(K_MINUS, 10);
    fill_to(130);
    exp_sw_n = 2; exp_idx[0] = 3; exp_off[0] = 7; exp_idx[1] = 9; exp_off[1] = 5;
    drive(13);
    check_all(13, "R6");
  endtask

  // R7: both enables low
  task automatic t_hold();
    apply_reset();
    plus_en = 1'b0; minus_en = 1'b0;
    fill_to(34); push_n(K_PLUS, 10);
    fill_to(58); push_n(K_MINUS, 10);
    fill_to(100);
    drive(10);
    check_all(10, "R7");
  endtask

  // R8, R2: plus at offset 1 and minus at offset 8 in one search
  task automatic t_prio();
    apply_reset();
    plus_en = 1'b1; minus_en = 1'b1;
    fill_to(51);
    push_n({3'b000, P_PAT}, 7);
    push_n({3'b000, M_PAT}, 7);
    fill_to(110);
    exp_sw_n = 1; exp_idx[0] = 5; exp_off[0] = 1;
    drive(11);
    check_all(11, "R8");
  endtask

  // R10: back-pressure and input gaps
  task automatic t_bp();
    apply_reset();
    plus_en = 1'b0; minus_en = 1'b0;
    for (int i = 0; i < 20; i++) push_n(10'((i * 113 + 29) % 1024), 10);
    bp_en = 1'b1; gap_en = 1'b1;
    drive(20);
    bp_en = 1'b0;
    check_all(20, "R10");
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_passthru();
    t_plus();
    t_minus();
    t_hold();
    t_prio();
    t_bp();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule